// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is a memory-mapped general-purpose I/O controller that serves a parameterised number of banks of 32 pins each, five by default, for 160 pins. A plain 32-bit register bus reaches it with an address, a write strobe, write data and read data. Each bank has a direction word, an output-data word, a pair of mask words that set or clear output bits without a read-modify-write, and an input-data word that shows the synchronised level of every pin.

Software picks a pin's role through its direction bit. A pin set as an output drives its output-data bit and has its output enable asserted. Several agents can flip different output bits at the same time through the set and clear words, since only the bits marked in the mask change. Input levels pass through a two-flop synchronizer. A pin driven by the block therefore shows its new level in the input-data word only two clock edges after it reaches the pin. Reads are combinational from the address. Writes land on the clock edge on which the write strobe is sampled.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is applied and after it is released, every direction bit is 1, every output-data bit is 0 and every `pin_oe` bit is 0.
- R2: Writing the direction word of a bank (bank base + 0x00) stores the value. For each bit, a 1 makes the pin an input with `pin_oe` low and a 0 makes it an output with `pin_oe` high. The value reads back at the same address.
- R3: Writing the output-data word (bank base + 0x04) replaces that bank's `pin_out` bits after the next clock edge. The value reads back at that address.
- R4: Writing a mask to the set word (bank base + 0x08) forces the output-data bits that are 1 in the mask to 1 and leaves the other bits unchanged.
- R5: Writing a mask to the clear word (bank base + 0x0C) forces the output-data bits that are 1 in the mask to 0 and leaves the other bits unchanged.
- R6: Reading the set word or the clear word returns the current output-data value.
- R7: The input-data word (bank base + 0x10) returns `pin_in` delayed by a two-flop synchronizer. A level present on `pin_in` before clock edge k can be read after edge k+1, and not after edge k.
- R8: The input-data word shows the pin level for every pin, including pins set as outputs. It does not show the output-data value.
- R9: An access to any address that is not one of the five words of a bank reads as zero and changes no state. This includes addresses below the first base, gaps between banks, addresses past the last bank and addresses that are not word-aligned.
- R10: Writes to the input-data word have no effect.
- R11: Bank b starts at byte address 0x10 + 0x28*b. Pin n belongs to bank n/32 at bit n%32 of each of its words.
- R12: `pin_out` and `pin_oe` change only on a clock edge that samples a bus write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 160 | Pin levels from the pads, asynchronous |
| pin_out | output | 160 | Output-data value driven toward the pins |
| pin_oe | output | 160 | Per-pin output enable, high for outputs |

## Verification
Three results have fixed delays. Read data follows the address in the same cycle. A register write shows on `pin_out`, `pin_oe` and read data one edge after the edge that samples it. A pin level reaches the input-data word two edges after it appears. The bench drives inputs on falling edges. The scoreboard monitor compares each queued read one time unit after the next rising edge, which places every write and one synchronizer stage before the sample. The synchronizer test samples the input word after the first edge and again after the second edge, and expects the old level and then the new level.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned WORDS_PER_BANK = 5;

  // word index inside a bank equals the offset divided by 4
  typedef enum logic [2:0] {
    K_DIR  = 3'd0,
    K_OUT  = 3'd1,
    K_SET  = 3'd2,
    K_CLR  = 3'd3,
    K_IN   = 3'd4,
    K_NONE = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned BASE      = 16,
  parameter int unsigned STRIDE    = 40
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output reg_kind_e            kind
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WORDS_PER_BANK * 4);

  logic [2:0] word_idx [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE + b * STRIDE);
    logic [ADDR_W-1:0] rel;
    assign rel         = addr - LO;
    assign bank_hit[b] = (addr >= LO) && (rel < SPAN) && (rel[1:0] == 2'b00);
    assign word_idx[b] = rel[4:2];
  end

  always_comb begin
    kind = K_NONE;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) kind = reg_kind_e'(word_idx[b]);
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         we,
  input  reg_kind_e    kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] in_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (sel && we) begin
      case (kind)
        K_DIR:   dir_q <= wdata;
        K_OUT:   out_q <= wdata;
        K_SET:   out_q <= out_q | wdata;
        K_CLR:   out_q <= out_q & ~wdata;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins),
    .q    (in_q)
  );
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 5,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE        = 16,
  parameter int unsigned STRIDE      = 40,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPINS      = NUM_BANKS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  logic [NUM_BANKS-1:0] hit;
  reg_kind_e            kind;
  logic [DATA_W-1:0]    dir_w [NUM_BANKS];
  logic [DATA_W-1:0]    out_w [NUM_BANKS];
  logic [DATA_W-1:0]    in_w  [NUM_BANKS];

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BASE(BASE), .STRIDE(STRIDE)
  ) u_dec (
    .addr    (bus_addr),
    .bank_hit(hit),
    .kind    (kind)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (hit[b]),
      .we   (bus_we),
      .kind (kind),
      .wdata(bus_wdata),
      .pins (pin_in[b*DATA_W +: DATA_W]),
      .dir_q(dir_w[b]),
      .out_q(out_w[b]),
      .in_q (in_w[b])
    );
    assign pin_out[b*DATA_W +: DATA_W] = out_w[b];
    assign pin_oe[b*DATA_W +: DATA_W]  = ~dir_w[b];
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) begin
        case (kind)
          K_DIR:                  bus_rdata = dir_w[b];
          K_OUT, K_SET, K_CLR:    bus_rdata = out_w[b];
          K_IN:                   bus_rdata = in_w[b];
          default:                bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned NUM_BANKS   = 5,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPINS      = NUM_BANKS * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe
);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(BASE + 8);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE + 12);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(BASE + 16);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_oe == '0) && (pin_out == '0));

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIR) |=> pin_oe[DATA_W-1:0] == ~$past(bus_wdata));

  p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET) |=>
      (pin_out[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata));

  p_set_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET) |=>
      ((pin_out[DATA_W-1:0] ^ $past(pin_out[DATA_W-1:0])) & ~$past(bus_wdata)) == '0);

  p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR) |=> (pin_out[DATA_W-1:0] & $past(bus_wdata)) == '0);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < A_DIR) |-> bus_rdata == '0);

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_out) && $stable(pin_oe));

  if (SYNC_STAGES == 2) begin : g_lat
    p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && !bus_we && bus_addr == A_IN) |->
        bus_rdata == $past(pin_in[DATA_W-1:0], 2));
  end
endmodule

bind gpio_port_ctrl gpio_port_chk #(
  .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .BASE(BASE), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [159:0] pin_in = '0;
  logic [159:0] pin_out;
  logic [159:0] pin_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #4 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  // driver: queue the expected read, monitor compares after the next edge
  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin : monitor
    rd_item_t it;
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        chk($sformatf("%s rd@%02h", it.tag, it.addr), bus_rdata, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 oe in reset", pin_oe[31:0], 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe bank0", pin_oe[31:0], 32'h0);
    chk("R1 oe bank4", pin_oe[159:128], 32'h0);
    chk("R1 out bank0", pin_out[31:0], 32'h0);
    rd(8'h10, 32'hFFFF_FFFF, "R1 dir");
    rd(8'h14, 32'h0, "R1 out");

    // R2 direction
    wr(8'h10, 32'hFFFF_0000);
    chk("R2 oe", pin_oe[31:0], 32'h0000_FFFF);
    rd(8'h10, 32'hFFFF_0000, "R2 dir");

    // R3 output data
    wr(8'h14, 32'hA5A5_0F0F);
    chk("R3 pins", pin_out[31:0], 32'hA5A5_0F0F);
    rd(8'h14, 32'hA5A5_0F0F, "R3 out");

    // R4 set mask
    wr(8'h18, 32'h0000_F0F0);
    chk("R4 pins", pin_out[31:0], 32'hA5A5_FFFF);
    rd(8'h14, 32'hA5A5_FFFF, "R4 out");

    // R5 clear mask
    wr(8'h1C, 32'hA000_000F);
    chk("R5 pins", pin_out[31:0], 32'h05A5_FFF0);
    rd(8'h14, 32'h05A5_FFF0, "R5 out");

    // R6 set/clear readback
    rd(8'h18, 32'h05A5_FFF0, "R6 set");
    rd(8'h1C, 32'h05A5_FFF0, "R6 clr");

    // R7 synchronizer latency
    @(negedge clk);
    bus_addr = 8'h20;
    pin_in[31:0] = 32'h1234_5678;
    @(posedge clk); #1;
    chk("R7 after one edge", bus_rdata, 32'h0);
    @(posedge clk); #1;
    chk("R7 after two edges", bus_rdata, 32'h1234_5678);

    // R8 outputs still read the pin level
    rd(8'h20, 32'h1234_5678, "R8 in");

    // R11 bank placement
    wr(8'h8C, 32'h0000_0010);
    wr(8'h88, 32'hFFFF_FFEF);
    chk("R11 pin100 out", {31'h0, pin_out[100]}, 32'h1);
    chk("R11 bank3 out", pin_out[127:96], 32'h0000_0010);
    chk("R11 bank3 oe", pin_oe[127:96], 32'h0000_0010);
    pin_in[159:128] = 32'hCAFE_F00D;
    rd(8'hC0, 32'hCAFE_F00D, "R11 bank4 in");
    rd(8'h38, 32'hFFFF_FFFF, "R11 bank1 dir");
    rd(8'h68, 32'h0, "R11 bank2 set");

    // R9 unmapped
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'hC4, 32'hFFFF_FFFF);
    wr(8'h12, 32'h0000_0000);
    wr(8'h15, 32'h0000_0000);
    rd(8'h10, 32'hFFFF_0000, "R9 dir kept");
    rd(8'h14, 32'h05A5_FFF0, "R9 out kept");
    chk("R9 bank4 out", pin_out[159:128], 32'h0);
    rd(8'h00, 32'h0, "R9 low");
    rd(8'h24, 32'h0, "R9 gap");
    rd(8'hC4, 32'h0, "R9 high");
    rd(8'h12, 32'h0, "R9 unaligned");

    // R10 input word not writable
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h1234_5678, "R10 in");
    rd(8'h14, 32'h05A5_FFF0, "R10 out");
    rd(8'h10, 32'hFFFF_0000, "R10 dir");

    // R12 pins hold without writes
    pin_in = ~pin_in;
    repeat (4) @(negedge clk);
    chk("R12 out", pin_out[31:0], 32'h05A5_FFF0);
    chk("R12 oe", pin_oe[31:0], 32'h0000_FFFF);
    chk("R12 bank3 oe", pin_oe[127:96], 32'h0000_0010);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule